// File: doc/BRIEF.md
# Programmable Address-Decoded Chip-Select Port

This block drives four output pins. Each pin works in one of two ways. It can be a plain general-purpose output bit taken from a port latch. It can also be a chip-select strobe that fires when the bus address matches that pin's programmable 16-bit base address and the chosen bus strobe is active. A strobe pin can fire on reads, on writes or on both. It also has a selectable compare length, so one pin can cover a 1, 2, 4 or 256 byte window, and its own active polarity.

Configuration is held in small byte-wide registers that are written through a simple write port. The pin values are formed combinationally from the bus address and the read and write strobes. External peripherals can therefore use them as select lines in the same cycle as the access.

Top module: `cs_port`

## Requirements
- R1: After a synchronous reset, the port latch holds all ones and all base, control and polarity registers hold zero, so every pin reads 1.
- R2: Register map, written on a rising edge with reg_we high. Addresses 0 to 7 hold the base bytes, with pin n low byte at 2n and high byte at 2n+1. Address 8 holds control for pins 0 and 1, and address 9 holds control for pins 2 and 3. The even pin uses bits [3:0] and the odd pin uses bits [7:4]. Within each nibble, bits [3:2] are the function and bits [1:0] are the compare code. Address 10 bits [3:0] are the per-pin polarity, address 11 bits [3:0] are the port latch, and writes to other addresses change nothing.
- R3: With function 00, a pin outputs its port latch bit whatever the bus does.
- R4: With function 01, a pin is active only while bus_rd is high and the address matches; bus_wr is ignored.
- R5: With function 10, a pin is active only while bus_wr is high and the address matches; bus_rd is ignored.
- R6: With function 11, a pin is active while bus_rd or bus_wr is high and the address matches.
- R7: Compare code 00 matches all 16 address bits. Code 01 ignores bit 0, code 10 ignores bits 1:0, and code 11 ignores bits 7:0.
- R8: In a strobe mode, polarity bit 1 gives an active-high pin and polarity bit 0 gives an active-low pin. An inactive pin drives the inverse of its active level.
- R9: Pin outputs follow bus_addr, bus_rd and bus_wr in the same cycle, while a register write changes the pins only after the clock edge that stores it.
- R10: Each pin decodes its own base, function, compare code and polarity, independently of the other pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| bus_addr | input | 16 | Bus address under decode |
| bus_rd | input | 1 | Bus read strobe, active high |
| bus_wr | input | 1 | Bus write strobe, active high |
| pin_o | output | 4 | Pin values, bit n is pin n |

## Verification
The pin values have no register between the bus inputs and the outputs, so they are due in the same cycle as any change of bus_addr, bus_rd or bus_wr. The bench drives the bus at a falling edge and samples pin_o 1 ns later, well before the next rising edge. A register write is driven at a falling edge, stored at the following rising edge and checked at the next falling edge. For one polarity write, the pin is also checked before that edge to show the old value still holds.

// File: rtl/cs_port_pkg.sv
package cs_port_pkg;
  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_RD   = 2'b01,
    FN_WR   = 2'b10,
    FN_RW   = 2'b11
  } fn_e;

  localparam int FIELD_W = 4;  // per-pin control nibble: {fn[1:0], cmp[1:0]}
endpackage

// File: rtl/cs_port_regs.sv
module cs_port_regs
  import cs_port_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int RAW   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [RAW-1:0]        addr,
  input  logic [DW-1:0]         wdata,
  output logic [NPINS*AW-1:0]   base_o,
  output logic [NPINS*FIELD_W-1:0] ctl_o,
  output logic [NPINS-1:0]      pol_o,
  output logic [NPINS-1:0]      lat_o
);
  localparam int BPP      = AW / DW;
  localparam int CTL_BASE = NPINS * BPP;
  localparam int NCTL     = (NPINS * FIELD_W) / DW;
  localparam int POL_ADDR = CTL_BASE + NCTL;
  localparam int LAT_ADDR = POL_ADDR + 1;

  logic [NPINS*AW-1:0]      base_q;
  logic [NPINS*FIELD_W-1:0] ctl_q;
  logic [NPINS-1:0]         pol_q;
  logic [NPINS-1:0]         lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ctl_q  <= '0;
      pol_q  <= '0;
      lat_q  <= '1;
    end else if (we) begin
      for (int i = 0; i < NPINS; i++) begin
        for (int k = 0; k < BPP; k++) begin
          if (addr == RAW'(i * BPP + k)) base_q[i*AW + k*DW +: DW] <= wdata;
        end
      end
      for (int c = 0; c < NCTL; c++) begin
        if (addr == RAW'(CTL_BASE + c)) ctl_q[c*DW +: DW] <= wdata;
      end
      if (addr == RAW'(POL_ADDR)) pol_q <= wdata[NPINS-1:0];
      if (addr == RAW'(LAT_ADDR)) lat_q <= wdata[NPINS-1:0];
    end
  end

  assign base_o = base_q;
  assign ctl_o  = ctl_q;
  assign pol_o  = pol_q;
  assign lat_o  = lat_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lat_q == '1 && pol_q == '0 && ctl_q == '0 && base_q == '0));

  // R2
  pol_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == RAW'(POL_ADDR)) |=> (pol_q == $past(wdata[NPINS-1:0])));

  // R2
  pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == RAW'(POL_ADDR)) |=> $stable(pol_q));
endmodule

// File: rtl/cs_port_match.sv
module cs_port_match
  import cs_port_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] base,
  input  logic [1:0]    fn,
  input  logic [1:0]    cmp,
  input  logic          pol,
  input  logic          lat,
  output logic          pin_o
);
  localparam int HALF = AW / 2;

  logic [AW-1:0] mask;
  logic          hit;
  logic          act;

  always_comb begin
    case (cmp)
      2'b00:   mask = '1;
      2'b01:   mask = {{(AW-1){1'b1}}, 1'b0};
      2'b10:   mask = {{(AW-2){1'b1}}, 2'b00};
      default: mask = {{(AW-HALF){1'b1}}, {HALF{1'b0}}};
    endcase
  end

  assign hit   = ((addr ^ base) & mask) == '0;
  assign act   = hit & ((fn[0] & rd) | (fn[1] & wr));
  assign pin_o = (fn == FN_GPIO) ? lat : ~(act ^ pol);

  // R4
  rd_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FN_RD && !rd) |-> (pin_o == !pol));

  // R5
  wr_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FN_WR && !wr) |-> (pin_o == !pol));

  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fn != FN_GPIO && !rd && !wr) |-> (pin_o == !pol));
endmodule

// File: rtl/cs_port.sv
module cs_port
  import cs_port_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int RAW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_rd,
  input  logic           bus_wr,
  output logic [NPINS-1:0] pin_o
);
  logic [NPINS*AW-1:0]      base;
  logic [NPINS*FIELD_W-1:0] ctl;
  logic [NPINS-1:0]         pol;
  logic [NPINS-1:0]         lat;

  cs_port_regs #(.NPINS(NPINS), .AW(AW), .DW(DW), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .base_o(base), .ctl_o(ctl), .pol_o(pol), .lat_o(lat)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    cs_port_match #(.AW(AW)) u_match (
      .clk(clk), .rst(rst),
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .base(base[p*AW +: AW]),
      .fn(ctl[p*FIELD_W+2 +: 2]),
      .cmp(ctl[p*FIELD_W +: 2]),
      .pol(pol[p]), .lat(lat[p]),
      .pin_o(pin_o[p])
    );
  end
endmodule

// File: tb/cs_port_bench.sv
module cs_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  pin_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cs_port u_cs_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .pin_o(pin_o)
  );

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s pin_o=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic bus(input logic [15:0] a, input logic r, input logic w);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 reset pins", pin_o, 4'b1111);
  endtask

  task automatic t_gpio;
    wreg(4'd11, 8'h0A);
    chk("R3 gpio latch", pin_o, 4'b1010);
    bus(16'h0000, 1'b1, 1'b1);
    chk("R3 gpio ignores bus", pin_o, 4'b1010);
    bus(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_read;
    wreg(4'd0, 8'h34); wreg(4'd1, 8'h12);
    wreg(4'd8, 8'h04);  // pin0: read strobe, full compare, active low
    chk("R8 rd idle high", pin_o, 4'b1011);
    bus(16'h1234, 1'b1, 1'b0);
    chk("R4 rd match", pin_o, 4'b1010);
    bus(16'h1234, 1'b0, 1'b1);
    chk("R4 wr ignored", pin_o, 4'b1011);
    bus(16'h1235, 1'b1, 1'b0);
    chk("R7 full compare miss", pin_o, 4'b1011);
    bus(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_write;
    wreg(4'd2, 8'hC3); wreg(4'd3, 8'hA5);
    wreg(4'd8, 8'h84);  // pin1: write strobe, full compare
    wreg(4'd10, 8'h02); // pin1 active high
    chk("R8 active high idle", pin_o, 4'b1001);
    bus(16'hA5C3, 1'b0, 1'b1);
    chk("R5 wr match", pin_o, 4'b1011);
    bus(16'hA5C3, 1'b1, 1'b0);
    chk("R5 rd ignored", pin_o, 4'b1001);
    bus(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_both;
    wreg(4'd4, 8'h00); wreg(4'd5, 8'h80);
    wreg(4'd9, 8'h0F);  // pin2: read/write, compare high byte
    chk("R6 idle", pin_o, 4'b1101);
    bus(16'h80FF, 1'b1, 1'b0);
    chk("R6 rd hit", pin_o, 4'b1001);
    bus(16'h80FF, 1'b0, 1'b1);
    chk("R6 wr hit", pin_o, 4'b1001);
    bus(16'h81FF, 1'b1, 1'b0);
    chk("R7 high byte miss", pin_o, 4'b1101);
    bus(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_cmp;
    wreg(4'd6, 8'h00); wreg(4'd7, 8'h40);
    wreg(4'd9, 8'h5F);  // pin3: read, ignore bit 0
    bus(16'h4001, 1'b1, 1'b0);
    chk("R7 code01 hit R10", pin_o, 4'b0101);
    bus(16'h4002, 1'b1, 1'b0);
    chk("R7 code01 miss", pin_o, 4'b1101);
    wreg(4'd9, 8'h6F);  // pin3: read, ignore bits 1:0
    bus(16'h4003, 1'b1, 1'b0);
    chk("R7 code10 hit", pin_o, 4'b0101);
    bus(16'h4004, 1'b1, 1'b0);
    chk("R7 code10 miss", pin_o, 4'b1101);
    bus(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_pol;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd10; reg_wdata = 8'h0A;
    #1;
    chk("R9 before edge", pin_o, 4'b1101);
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    chk("R9 after edge R8", pin_o, 4'b0101);
    bus(16'h4000, 1'b1, 1'b0);
    chk("R8 active high hit", pin_o, 4'b1101);
    bus(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_ignore;
    wreg(4'd12, 8'hFF);
    wreg(4'd15, 8'hFF);
    chk("R2 unmapped write", pin_o, 4'b0101);
    bus(16'h4000, 1'b1, 1'b0);
    chk("R2 unmapped kept config", pin_o, 4'b1101);
    bus(16'h0000, 1'b0, 1'b0);
    wreg(4'd8, 8'h00);  // pins 0,1 back to GPIO, latch still 1010
    chk("R3 back to gpio", pin_o, 4'b0110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_gpio();
    t_read();
    t_write();
    t_both();
    t_cmp();
    t_pol();
    t_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule